// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node directory for a small multiprocessor that keeps caches coherent by invalidation. For each memory block it records one of three states (uncached, shared, exclusive) together with a bit-vector of the nodes that hold a copy. It also keeps the home copy of the data. Processor nodes send it read misses, write misses and write-backs of dirty blocks. It answers with data replies and sends fetch, invalidate and fetch-and-invalidate messages to caches.

Requests arrive one at a time on a valid/ready port. When a block is exclusive, the owner holds the only current copy. Any miss to that block is routed through the home node. The controller sends a message to the owner and stops accepting requests. It waits for the owner's data, writes that data into home memory, and forwards it to the requester. Data never passes directly from one cache to another.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is uncached with an empty sharer set, every home data word reads as zero, `req_ready` is 1, and `rsp_valid` and `msg_valid` are 0.
- R2: A read miss (`req_type` 0) to an uncached or shared block produces a data reply from home memory in the cycle after acceptance, with no cache message. The requester joins the sharer set and the block becomes shared.
- R3: A write miss (`req_type` 1) to an uncached block produces a data reply from home memory in the cycle after acceptance, with no cache message. The requester becomes the sole owner and the block becomes exclusive.
- R4: A write miss to a shared block produces a data reply from memory in the cycle after acceptance. If any sharer other than the requester exists, one invalidate message (`msg_type` 2) is sent in the same cycle, and its mask bit i is set for each such node i. The requester becomes the sole owner and the block becomes exclusive.
- R5: A read miss to an exclusive block sends a fetch message (`msg_type` 1) whose mask is the owner only. When the owner's data arrives, it is written to home memory and replied to the requester in the next cycle. Both nodes are then sharers and the block is shared.
- R6: A write miss to an exclusive block sends a fetch-and-invalidate message (`msg_type` 3) to the owner only. The owner's data is written to home memory and replied to the requester. The requester becomes the sole owner and the block stays exclusive.
- R7: A write-back (`req_type` 2) from the owner of an exclusive block writes `req_data` into home memory and leaves the block uncached with no sharers. No reply and no message are produced.
- R8: A write-back from a node that is not the owner of an exclusive block changes neither home memory nor the directory, and produces no reply and no message.
- R9: From the acceptance of a miss to an exclusive block until the owner's data arrives, `req_ready` is 0 and offered requests are not taken.
- R10: Owner data offered while no fetch is pending is ignored: it produces no reply and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_node | input | NODE_W | Requesting node number |
| req_addr | input | ADDR_W | Block index |
| req_data | input | DATA_W | Write-back data |
| own_valid | input | 1 | Owner data return is valid |
| own_data | input | DATA_W | Data returned by the owner |
| rsp_valid | output | 1 | Data reply pulse |
| rsp_node | output | NODE_W | Node the reply is addressed to |
| rsp_addr | output | ADDR_W | Block of the reply |
| rsp_data | output | DATA_W | Reply data |
| msg_valid | output | 1 | Cache message pulse |
| msg_type | output | 2 | 1 fetch, 2 invalidate, 3 fetch-and-invalidate |
| msg_mask | output | NODES | Destination nodes, bit i for node i |
| msg_addr | output | ADDR_W | Block the message refers to |

## Verification
The hardest states to reach from the ports are the busy window after a miss to an exclusive block, and the write-back that arrives from a node that is not the owner. The stimulus reaches the busy window by writing to random blocks and then missing on them from other nodes. While the controller waits, the bench sometimes drives owner data late and offers stray requests. The owner's own misses are turned into write-backs. Write-backs from random nodes are kept, and any that come from non-owners must leave every later reply unchanged.

// File: rtl/dir_pkg.sv
// Shared encodings for the home directory controller.
// Assumes: request and message codes are fixed by the node interface.
package dir_pkg;
    typedef enum logic [1:0] {
        BLK_UNC = 2'd0,
        BLK_SHR = 2'd1,
        BLK_EXC = 2'd2
    } blk_state_t;

    typedef enum logic [1:0] {
        REQ_READ  = 2'd0,
        REQ_WRITE = 2'd1,
        REQ_WBACK = 2'd2,
        REQ_RSVD  = 2'd3
    } req_kind_t;

    typedef enum logic [1:0] {
        MSG_NONE      = 2'd0,
        MSG_FETCH     = 2'd1,
        MSG_INVAL     = 2'd2,
        MSG_FETCH_INV = 2'd3
    } msg_kind_t;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_WAIT = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/dir_state_store.sv
// Per-block directory entries: coherence state and sharer vector.
// Assumes: one read port (combinational) and one write port; reset clears all.
module dir_state_store
    import dir_pkg::*;
#(
    parameter int BLOCKS = 8,
    parameter int NODES  = 4,
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output blk_state_t        rd_state,
    output logic [NODES-1:0]  rd_sharers,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  blk_state_t        wr_state,
    input  logic [NODES-1:0]  wr_sharers
);
    blk_state_t       state_q   [BLOCKS];
    logic [NODES-1:0] sharers_q [BLOCKS];

    // Combinational lookup of the addressed entry.
    assign rd_state   = state_q[rd_addr];
    assign rd_sharers = sharers_q[rd_addr];

    // Entry update; reset makes every block uncached with no sharers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) begin
                state_q[b]   <= BLK_UNC;
                sharers_q[b] <= '0;
            end
        end else if (wr_en) begin
            state_q[wr_addr]   <= wr_state;
            sharers_q[wr_addr] <= wr_sharers;
        end
    end
endmodule

// File: rtl/dir_data_mem.sv
// Home copy of block data.
// Assumes: small array, combinational read, one write port, zeroed at reset.
module dir_data_mem #(
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] words_q [BLOCKS];

    // Combinational read of the addressed word.
    assign rd_data = words_q[rd_addr];

    // Word write; reset clears the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) begin
                words_q[b] <= '0;
            end
        end else if (wr_en) begin
            words_q[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/dir_decide.sv
// Decides the response to a newly accepted request from the current entry.
// Assumes: a miss to an exclusive block never comes from the owner itself.
module dir_decide
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  req_kind_t         kind,
    input  logic [NODE_W-1:0] node,
    input  blk_state_t        cur_state,
    input  logic [NODES-1:0]  cur_sharers,
    output logic [NODES-1:0]  node_mask,
    output logic              dir_wr,
    output blk_state_t        new_state,
    output logic [NODES-1:0]  new_sharers,
    output logic              send_rsp,
    output logic              mem_wr,
    output logic              go_wait,
    output msg_kind_t         msg_kind,
    output logic [NODES-1:0]  msg_mask
);
    logic [NODES-1:0] others;

    // One-hot decode of the requesting node.
    for (genvar i = 0; i < NODES; i++) begin : g_dec
        assign node_mask[i] = (node == NODE_W'(i));
    end

    assign others = cur_sharers & ~node_mask;

    // Action table per request kind and block state.
    always_comb begin
        dir_wr      = 1'b0;
        new_state   = cur_state;
        new_sharers = cur_sharers;
        send_rsp    = 1'b0;
        mem_wr      = 1'b0;
        go_wait     = 1'b0;
        msg_kind    = MSG_NONE;
        msg_mask    = '0;
        case (kind)
            REQ_READ: begin
                if (cur_state == BLK_EXC) begin
                    msg_kind = MSG_FETCH;
                    msg_mask = cur_sharers;
                    go_wait  = 1'b1;
                end else begin
                    send_rsp    = 1'b1;
                    dir_wr      = 1'b1;
                    new_state   = BLK_SHR;
                    new_sharers = cur_sharers | node_mask;
                end
            end
            REQ_WRITE: begin
                if (cur_state == BLK_EXC) begin
                    msg_kind = MSG_FETCH_INV;
                    msg_mask = cur_sharers;
                    go_wait  = 1'b1;
                end else begin
                    if (others != '0) begin
                        msg_kind = MSG_INVAL;
                        msg_mask = others;
                    end
                    send_rsp    = 1'b1;
                    dir_wr      = 1'b1;
                    new_state   = BLK_EXC;
                    new_sharers = node_mask;
                end
            end
            REQ_WBACK: begin
                if (cur_state == BLK_EXC && cur_sharers == node_mask) begin
                    mem_wr      = 1'b1;
                    dir_wr      = 1'b1;
                    new_state   = BLK_UNC;
                    new_sharers = '0;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dir_home_ctrl.sv
// Home directory controller: accepts one request at a time, keeps the
// directory and home memory, routes all owner data through the home node.
// Assumes: owner data arrives only after a fetch; request port single-issue.
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_type,
    input  logic [NODE_W-1:0] req_node,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              own_valid,
    input  logic [DATA_W-1:0] own_data,
    output logic              rsp_valid,
    output logic [NODE_W-1:0] rsp_node,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DATA_W-1:0] rsp_data,
    output logic              msg_valid,
    output logic [1:0]        msg_type,
    output logic [NODES-1:0]  msg_mask,
    output logic [ADDR_W-1:0] msg_addr
);
    ctl_state_t        ctl_q;
    req_kind_t         pend_kind_q;
    logic [NODE_W-1:0] pend_node_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [NODES-1:0]  pend_mask_q;
    logic [NODES-1:0]  pend_sharers_q;

    blk_state_t        cur_state;
    logic [NODES-1:0]  cur_sharers;
    logic [DATA_W-1:0] mem_rd_data;

    logic              accept;
    logic              fill_done;
    logic [NODES-1:0]  node_mask;
    logic              d_dir_wr;
    blk_state_t        d_state;
    logic [NODES-1:0]  d_sharers;
    logic              d_rsp;
    logic              d_mem_wr;
    logic              d_wait;
    msg_kind_t         d_msg;
    logic [NODES-1:0]  d_msg_mask;

    logic              st_wr;
    logic [ADDR_W-1:0] st_wr_addr;
    blk_state_t        st_wr_state;
    logic [NODES-1:0]  st_wr_sharers;
    logic              mem_wr;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [DATA_W-1:0] mem_wr_data;

    assign req_ready = (ctl_q == CTL_IDLE);
    assign accept    = req_valid && req_ready;
    assign fill_done = own_valid && (ctl_q == CTL_WAIT);

    dir_state_store #(.BLOCKS(BLOCKS), .NODES(NODES)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (req_addr),
        .rd_state   (cur_state),
        .rd_sharers (cur_sharers),
        .wr_en      (st_wr),
        .wr_addr    (st_wr_addr),
        .wr_state   (st_wr_state),
        .wr_sharers (st_wr_sharers)
    );

    dir_data_mem #(.BLOCKS(BLOCKS), .DATA_W(DATA_W)) i_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (req_addr),
        .rd_data (mem_rd_data),
        .wr_en   (mem_wr),
        .wr_addr (mem_wr_addr),
        .wr_data (mem_wr_data)
    );

    dir_decide #(.NODES(NODES)) i_decide (
        .kind        (req_kind_t'(req_type)),
        .node        (req_node),
        .cur_state   (cur_state),
        .cur_sharers (cur_sharers),
        .node_mask   (node_mask),
        .dir_wr      (d_dir_wr),
        .new_state   (d_state),
        .new_sharers (d_sharers),
        .send_rsp    (d_rsp),
        .mem_wr      (d_mem_wr),
        .go_wait     (d_wait),
        .msg_kind    (d_msg),
        .msg_mask    (d_msg_mask)
    );

    // Select directory and memory writes: new request or owner data return.
    always_comb begin
        st_wr         = 1'b0;
        st_wr_addr    = req_addr;
        st_wr_state   = d_state;
        st_wr_sharers = d_sharers;
        mem_wr        = 1'b0;
        mem_wr_addr   = req_addr;
        mem_wr_data   = req_data;
        if (fill_done) begin
            st_wr       = 1'b1;
            st_wr_addr  = pend_addr_q;
            mem_wr      = 1'b1;
            mem_wr_addr = pend_addr_q;
            mem_wr_data = own_data;
            if (pend_kind_q == REQ_READ) begin
                st_wr_state   = BLK_SHR;
                st_wr_sharers = pend_sharers_q | pend_mask_q;
            end else begin
                st_wr_state   = BLK_EXC;
                st_wr_sharers = pend_mask_q;
            end
        end else if (accept) begin
            st_wr  = d_dir_wr;
            mem_wr = d_mem_wr;
        end
    end

    // Controller state and the record of the transaction awaiting owner data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q          <= CTL_IDLE;
            pend_kind_q    <= REQ_READ;
            pend_node_q    <= '0;
            pend_addr_q    <= '0;
            pend_mask_q    <= '0;
            pend_sharers_q <= '0;
        end else if (fill_done) begin
            ctl_q <= CTL_IDLE;
        end else if (accept && d_wait) begin
            ctl_q          <= CTL_WAIT;
            pend_kind_q    <= req_kind_t'(req_type);
            pend_node_q    <= req_node;
            pend_addr_q    <= req_addr;
            pend_mask_q    <= node_mask;
            pend_sharers_q <= cur_sharers;
        end
    end

    // Registered reply and cache-message outputs, one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_node  <= '0;
            rsp_addr  <= '0;
            rsp_data  <= '0;
            msg_valid <= 1'b0;
            msg_type  <= MSG_NONE;
            msg_mask  <= '0;
            msg_addr  <= '0;
        end else begin
            rsp_valid <= fill_done || (accept && d_rsp);
            msg_valid <= accept && (d_msg != MSG_NONE);
            if (fill_done) begin
                rsp_node <= pend_node_q;
                rsp_addr <= pend_addr_q;
                rsp_data <= own_data;
            end else if (accept) begin
                rsp_node <= req_node;
                rsp_addr <= req_addr;
                rsp_data <= mem_rd_data;
            end
            if (accept) begin
                msg_type <= d_msg;
                msg_mask <= d_msg_mask;
                msg_addr <= req_addr;
            end
        end
    end
endmodule

// File: rtl/dir_home_chk.sv
// Protocol checker for the home directory controller, bound to the top.
// Assumes: observes ports only.
module dir_home_chk #(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_type,
    input logic              own_valid,
    input logic [DATA_W-1:0] own_data,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              msg_valid,
    input logic [1:0]        msg_type,
    input logic [NODES-1:0]  msg_mask
);
    // R9
    fetch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type != 2'd2) |-> !req_ready);
    // R9
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);
    // R5
    fetch_one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type != 2'd2) |-> ($countones(msg_mask) == 1));
    // R4
    inval_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == 2'd2) |-> (msg_mask != '0));
    // R6
    owner_data_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_valid && !req_ready) |=> (rsp_valid && rsp_data == $past(own_data)));
    // R7
    wback_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_type == 2'd2 && !own_valid) |=> (!rsp_valid && !msg_valid));
    // R10
    stray_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_valid && req_ready && !req_valid) |=> (!rsp_valid && !msg_valid));
endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_type  (req_type),
    .own_valid (own_valid),
    .own_data  (own_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .msg_valid (msg_valid),
    .msg_type  (msg_type),
    .msg_mask  (msg_mask)
);

// File: tb/test_dir_home_ctrl.sv
`timescale 1ns/1ps
module test_dir_home_ctrl;
    localparam int NODES  = 4;
    localparam int BLOCKS = 8;
    localparam int DW     = 16;
    localparam int NW     = 2;
    localparam int AW     = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_type = '0;
    logic [NW-1:0] req_node = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          own_valid = 1'b0;
    logic [DW-1:0] own_data = '0;
    logic          rsp_valid;
    logic [NW-1:0] rsp_node;
    logic [AW-1:0] rsp_addr;
    logic [DW-1:0] rsp_data;
    logic          msg_valid;
    logic [1:0]    msg_type;
    logic [NODES-1:0] msg_mask;
    logic [AW-1:0] msg_addr;

    int vectors = 0;
    int errors  = 0;

    int            m_st  [BLOCKS];
    logic [NODES-1:0] m_sh [BLOCKS];
    logic [DW-1:0] m_mem [BLOCKS];

    always #2 clk = ~clk;

    dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DW)) i_dir_home_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_node(req_node), .req_addr(req_addr), .req_data(req_data),
        .own_valid(own_valid), .own_data(own_data), .rsp_valid(rsp_valid), .rsp_node(rsp_node),
        .rsp_addr(rsp_addr), .rsp_data(rsp_data), .msg_valid(msg_valid), .msg_type(msg_type),
        .msg_mask(msg_mask), .msg_addr(msg_addr)
    );

    task automatic check(string req, string what, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NODES-1:0] onehot(int n);
        return NODES'(1) << n;
    endfunction

    // One request; expected values come from the bench model arrays.
    task automatic do_req(int kind, int node, int addr, logic [DW-1:0] wdata,
                          logic [DW-1:0] odata, int delay, bit stray);
        logic [NODES-1:0] m = onehot(node);
        logic [NODES-1:0] others = m_sh[addr] & ~m;
        bit excl = (m_st[addr] == 2);
        string tag;
        tag = (kind == 0) ? (excl ? "R5" : "R2") :
              (kind == 1) ? (excl ? "R6" : (m_st[addr] == 1 ? "R4" : "R3")) :
              ((excl && m_sh[addr] == m) ? "R7" : "R8");
        check("R9", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_type = 2'(kind); req_node = NW'(node);
        req_addr = AW'(addr); req_data = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        if (kind != 2 && excl) begin
            check(tag, "fetch msg valid", msg_valid, 1);
            check(tag, "fetch msg type", msg_type, (kind == 0) ? 1 : 3);
            check(tag, "fetch msg mask", msg_mask, m_sh[addr]);
            check(tag, "fetch msg addr", msg_addr, addr);
            check(tag, "no early reply", rsp_valid, 0);
            for (int d = 0; d < delay; d++) begin
                if (stray) begin
                    req_valid = 1'b1; req_type = 2'd2; req_node = NW'(node);
                end
                @(negedge clk);
                req_valid = 1'b0;
                check("R9", "busy ready", req_ready, 0);
                check("R9", "busy no reply", rsp_valid, 0);
            end
            own_valid = 1'b1; own_data = odata;
            @(negedge clk);
            own_valid = 1'b0;
            check(tag, "fill reply valid", rsp_valid, 1);
            check(tag, "fill reply data", rsp_data, odata);
            check(tag, "fill reply node", rsp_node, node);
            check(tag, "fill reply addr", rsp_addr, addr);
            check("R9", "ready after fill", req_ready, 1);
            m_mem[addr] = odata;
            if (kind == 0) begin m_st[addr] = 1; m_sh[addr] = m_sh[addr] | m; end
            else begin m_sh[addr] = m; end
        end else if (kind != 2) begin
            check(tag, "reply valid", rsp_valid, 1);
            check(tag, "reply data", rsp_data, m_mem[addr]);
            check(tag, "reply node", rsp_node, node);
            if (kind == 1 && others != '0) begin
                check(tag, "inval valid", msg_valid, 1);
                check(tag, "inval type", msg_type, 2);
                check(tag, "inval mask", msg_mask, others);
            end else begin
                check(tag, "no message", msg_valid, 0);
            end
            if (kind == 0) begin m_st[addr] = 1; m_sh[addr] = m_sh[addr] | m; end
            else begin m_st[addr] = 2; m_sh[addr] = m; end
        end else begin
            check(tag, "wback no reply", rsp_valid, 0);
            check(tag, "wback no message", msg_valid, 0);
            if (excl && m_sh[addr] == m) begin
                m_mem[addr] = wdata; m_st[addr] = 0; m_sh[addr] = '0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed1234);
        for (int b = 0; b < BLOCKS; b++) begin m_st[b] = 0; m_sh[b] = '0; m_mem[b] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", req_ready, 1);
        check("R1", "reply idle", rsp_valid, 0);
        check("R1", "message idle", msg_valid, 0);
        // R10: stray owner data while idle
        own_valid = 1'b1; own_data = 16'hdead;
        @(negedge clk);
        own_valid = 1'b0;
        check("R10", "stray data reply", rsp_valid, 0);
        // R1: uncached blocks read zero
        do_req(0, 1, 0, '0, '0, 0, 0);
        do_req(1, 2, 5, '0, '0, 0, 0);
        // directed: sharers then write with invalidate (R4)
        do_req(0, 0, 1, '0, '0, 0, 0);
        do_req(0, 3, 1, '0, '0, 0, 0);
        do_req(1, 0, 1, '0, '0, 0, 0);
        // R8: non-owner write-back ignored, then R7 owner write-back
        do_req(2, 2, 1, 16'h1111, '0, 0, 0);
        do_req(2, 0, 1, 16'h2222, '0, 0, 0);
        do_req(0, 1, 1, '0, '0, 0, 0);
        // R5 / R6 with busy window and stray requests
        do_req(1, 1, 3, '0, '0, 0, 0);
        do_req(0, 2, 3, '0, 16'habcd, 3, 1);
        do_req(1, 3, 3, '0, '0, 0, 0);
        do_req(1, 0, 3, '0, 16'h5a5a, 2, 1);
        do_req(0, 1, 3, '0, 16'h7777, 0, 0);
        for (int i = 0; i < 600; i++) begin
            int kind = int'($urandom_range(2, 0));
            int node = int'($urandom_range(NODES - 1, 0));
            int addr = int'($urandom_range(BLOCKS - 1, 0));
            if (m_st[addr] == 2 && m_sh[addr] == onehot(node)) kind = 2;
            do_req(kind, node, addr, 16'($urandom), 16'($urandom),
                   int'($urandom_range(3, 0)), 1'($urandom));
            if ($urandom_range(7, 0) == 0) begin
                own_valid = 1'b1; own_data = 16'($urandom);
                @(negedge clk);
                own_valid = 1'b0;
                check("R10", "stray data reply", rsp_valid, 0);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule